// File: doc/BRIEF.md
# Synchronous SRAM Sleep-Mode Sequencer

This block sequences power-down for a clocked SRAM wrapper that holds a small behavioural memory array. An asynchronous, active-high sleep request pin is brought into the clock domain through a flip-flop chain. A fixed number of cycles after the synchronized request rises, the block parks the array in a sleep state. In that state every command is ignored, the read-data enable is held low and the stored words stay as they are.

When the pin falls, the block opens a recovery window of a parameterized length. Inside that window reads and deselects are served normally and a write is refused and reported. A command issued while an entry is pending still executes, but the block reports it as a protocol violation, because sleep must only be requested on an idle bus.

Commands use a two-bit code: 2'b00 deselect, 2'b01 read, 2'b10 write, and 2'b11 behaves as a deselect. Reads are registered: the data and its bus enable appear in the cycle after the read is sampled.

Top module: `sram_sleep_ctrl`

## Requirements
- R1: After reset, `sleeping`, `recovering`, `rd_oe`, `wr_reject` and `busy_err` are all 0 and the block accepts commands.
- R2: With the default two-stage synchronizer and an entry delay of 2, `sleeping` rises after the fourth rising clock edge that follows a rising `sleep_pin` held high, and not before.
- R3: A `sleep_pin` pulse seen by only one sampling edge aborts the entry: `sleeping` and `recovering` stay 0.
- R4: While `sleeping` is 1, read commands produce no `rd_oe` and write commands change no stored word.
- R5: Every stored word keeps its value across a full sleep and recovery cycle.
- R6: After `sleep_pin` falls, `sleeping` drops and `recovering` rises on the third rising edge. `recovering` then stays high for exactly RECOV_CYC cycles (default 2), and the two flags are never high together.
- R7: A write (2'b10) sampled while `recovering` is 1 is not stored, and `wr_reject` is 1 for the single following cycle.
- R8: A read or write sampled while an entry is pending (the synchronized request is high in the awake state, or during the entry count) makes `busy_err` 1 for the following cycle.
- R9: A read (2'b01) sampled in the awake or recovery state drives `rd_oe` to 1 and `rd_data` to the addressed word in the next cycle. A write sampled in the awake state is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_pin | input | 1 | Asynchronous active-high sleep request |
| cmd | input | 2 | Command: 00 deselect, 01 read, 10 write, 11 deselect |
| addr | input | ADDR_W | Word address |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Registered read data, zero when not enabled |
| rd_oe | output | 1 | Data-bus drive enable (low means high impedance) |
| sleeping | output | 1 | Array is in the sleep state |
| recovering | output | 1 | Recovery window after wake-up is open |
| wr_reject | output | 1 | One-cycle pulse: a write was refused during recovery |
| busy_err | output | 1 | One-cycle pulse: a command was issued while entry was pending |

## Verification
The hardest case to reach from the ports is a read sampled on the last entry cycle. Its data is fetched, but it would surface in the first sleeping cycle, where the bus enable must stay low. The stimulus holds reads on `cmd` continuously from the cycle the pin rises. The scoreboard expects data only for the reads sampled before the entry edge. A stray enable from the final read therefore shows up as an unexpected item, and `busy_err` is checked on both entry cycles. Writes issued while asleep and inside the recovery window are followed by read-backs after wake-up, so any leak into the array shows up as a data mismatch.

// File: rtl/sram_sleep_pkg.sv
package sram_sleep_pkg;

   typedef enum logic [1:0] {
      CMD_DESEL = 2'b00,
      CMD_READ  = 2'b01,
      CMD_WRITE = 2'b10,
      CMD_RSVD  = 2'b11
   } cmd_e;

   typedef enum logic [1:0] {
      ST_AWAKE   = 2'b00,
      ST_ENTER   = 2'b01,
      ST_ASLEEP  = 2'b10,
      ST_RECOVER = 2'b11
   } pwr_state_e;

endpackage

// File: rtl/sram_sleep_sync.sv
module sram_sleep_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic sync_out
);

   if (STAGES < 2) begin : g_bad_stages
      $error("sram_sleep_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= 1'b0;
            else        chain[0] <= async_in;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= 1'b0;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/sram_sleep_fsm.sv
module sram_sleep_fsm
   import sram_sleep_pkg::*;
#(
   parameter int ENTRY_CYC = 2,
   parameter int RECOV_CYC = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req,
   output pwr_state_e state
);

   localparam int CNT_MAX = (ENTRY_CYC > RECOV_CYC) ? ENTRY_CYC : RECOV_CYC;
   localparam int CW      = $clog2(CNT_MAX + 1);
   localparam logic [CW-1:0] ENTRY_LAST = CW'(ENTRY_CYC - 2);
   localparam logic [CW-1:0] RECOV_LAST = CW'(RECOV_CYC - 1);

   if (ENTRY_CYC < 2) begin : g_bad_entry
      $error("sram_sleep_fsm: ENTRY_CYC must be at least 2");
   end
   if (RECOV_CYC < 1) begin : g_bad_recov
      $error("sram_sleep_fsm: RECOV_CYC must be at least 1");
   end

   pwr_state_e    state_q, state_d;
   logic [CW-1:0] cnt_q, cnt_d;

   always_comb begin
      state_d = state_q;
      cnt_d   = cnt_q;
      unique case (state_q)
         ST_AWAKE: begin
            if (req) begin
               state_d = ST_ENTER;
               cnt_d   = '0;
            end
         end
         ST_ENTER: begin
            if (!req) begin
               state_d = ST_AWAKE;
               cnt_d   = '0;
            end else if (cnt_q == ENTRY_LAST) begin
               state_d = ST_ASLEEP;
               cnt_d   = '0;
            end else begin
               cnt_d = cnt_q + 1'b1;
            end
         end
         ST_ASLEEP: begin
            if (!req) begin
               state_d = ST_RECOVER;
               cnt_d   = '0;
            end
         end
         ST_RECOVER: begin
            if (cnt_q == RECOV_LAST) begin
               state_d = ST_AWAKE;
               cnt_d   = '0;
            end else begin
               cnt_d = cnt_q + 1'b1;
            end
         end
         default: begin
            state_d = ST_AWAKE;
            cnt_d   = '0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_AWAKE;
         cnt_q   <= '0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
      end
   end

   assign state = state_q;

endmodule

// File: rtl/sram_sleep_gate.sv
module sram_sleep_gate
   import sram_sleep_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  pwr_state_e state,
   input  logic       req,
   input  cmd_e       cmd,
   output logic       rd_en,
   output logic       wr_en,
   output logic       wr_reject,
   output logic       busy_err
);

   logic is_rd, is_wr, pending, wr_hit, busy_hit;

   always_comb begin
      is_rd    = (cmd == CMD_READ);
      is_wr    = (cmd == CMD_WRITE);
      pending  = (state == ST_ENTER) || ((state == ST_AWAKE) && req);
      rd_en    = is_rd && (state != ST_ASLEEP);
      wr_en    = is_wr && ((state == ST_AWAKE) || (state == ST_ENTER));
      wr_hit   = is_wr && (state == ST_RECOVER);
      busy_hit = (is_rd || is_wr) && pending;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_reject <= 1'b0;
         busy_err  <= 1'b0;
      end else begin
         wr_reject <= wr_hit;
         busy_err  <= busy_hit;
      end
   end

endmodule

// File: rtl/sram_sleep_mem.sv
module sram_sleep_mem #(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic              wr_en,
   input  logic              bus_off,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_oe
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] store [DEPTH];
   logic [DATA_W-1:0] rd_q;
   logic              oe_q;

   always_ff @(posedge clk) begin
      if (wr_en) store[addr] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         oe_q <= 1'b0;
         rd_q <= '0;
      end else begin
         oe_q <= rd_en;
         if (rd_en) rd_q <= store[addr];
      end
   end

   assign rd_oe   = oe_q && !bus_off;
   assign rd_data = rd_oe ? rd_q : '0;

endmodule

// File: rtl/sram_sleep_ctrl.sv
module sram_sleep_ctrl
   import sram_sleep_pkg::*;
#(
   parameter int ADDR_W      = 4,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int ENTRY_CYC   = 2,
   parameter int RECOV_CYC   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sleep_pin,
   input  logic [1:0]        cmd,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_oe,
   output logic              sleeping,
   output logic              recovering,
   output logic              wr_reject,
   output logic              busy_err
);

   logic       req_sync;
   pwr_state_e state;
   logic       rd_en, wr_en;
   cmd_e       cmd_t;

   assign cmd_t = cmd_e'(cmd);

   sram_sleep_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (sleep_pin),
      .sync_out (req_sync)
   );

   sram_sleep_fsm #(.ENTRY_CYC(ENTRY_CYC), .RECOV_CYC(RECOV_CYC)) u_fsm (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (req_sync),
      .state (state)
   );

   sram_sleep_gate u_gate (
      .clk       (clk),
      .rst_n     (rst_n),
      .state     (state),
      .req       (req_sync),
      .cmd       (cmd_t),
      .rd_en     (rd_en),
      .wr_en     (wr_en),
      .wr_reject (wr_reject),
      .busy_err  (busy_err)
   );

   sram_sleep_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_en   (rd_en),
      .wr_en   (wr_en),
      .bus_off (sleeping),
      .addr    (addr),
      .wr_data (wr_data),
      .rd_data (rd_data),
      .rd_oe   (rd_oe)
   );

   assign sleeping   = (state == ST_ASLEEP);
   assign recovering = (state == ST_RECOVER);

endmodule

// File: rtl/sram_sleep_chk.sv
module sram_sleep_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       req_sync,
   input logic [1:0] cmd,
   input logic       rd_oe,
   input logic       sleeping,
   input logic       recovering,
   input logic       wr_reject
);

   p_flags_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(sleeping && recovering));

   p_no_drive_asleep_r4: assert property (@(posedge clk) disable iff (!rst_n)
      sleeping |-> !rd_oe);

   p_entry_after_sync_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sleeping) |-> ($past(req_sync) && $past(req_sync, 2)));

   p_stay_asleep_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (sleeping && req_sync) |=> sleeping);

   p_reject_in_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_reject |-> ($past(recovering) && ($past(cmd) == 2'b10)));

   p_window_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(recovering) |-> !sleeping);

   p_drive_from_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rd_oe |-> ($past(cmd) == 2'b01));

endmodule

bind sram_sleep_ctrl sram_sleep_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_sync   (req_sync),
   .cmd        (cmd),
   .rd_oe      (rd_oe),
   .sleeping   (sleeping),
   .recovering (recovering),
   .wr_reject  (wr_reject)
);

// File: tb/sram_sleep_ctrl_tb_top.sv
module sram_sleep_ctrl_tb_top;

   localparam int AW = 4;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sleep_pin = 1'b0;
   logic [1:0]    cmd = 2'b00;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic [DW-1:0] rd_data;
   logic          rd_oe, sleeping, recovering, wr_reject, busy_err;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   logic [DW-1:0] model [1 << AW];
   logic [DW-1:0] exp_q [$];

   always #2 clk = ~clk;

   sram_sleep_ctrl dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .sleep_pin  (sleep_pin),
      .cmd        (cmd),
      .addr       (addr),
      .wr_data    (wr_data),
      .rd_data    (rd_data),
      .rd_oe      (rd_oe),
      .sleeping   (sleeping),
      .recovering (recovering),
      .wr_reject  (wr_reject),
      .busy_err   (busy_err)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // driver: present one command for one cycle; push expected read data
   task automatic tick(input logic [1:0] c, input int a, input int d, input bit expect_rd);
      cmd     = c;
      addr    = AW'(a);
      wr_data = DW'(d);
      if (expect_rd) exp_q.push_back(model[a]);
      @(negedge clk);
   endtask

   // monitor: every enabled read must match the oldest expected item
   always @(negedge clk) begin
      if (rst_n && rd_oe) begin
         if (exp_q.size() == 0) begin
            checks++;
            failures++;
            $display("FAIL R4 unexpected rd_oe actual=1 expected=0 data=%0h", rd_data);
         end else begin
            chk("R9 read data", 32'(rd_data), 32'(exp_q.pop_front()));
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 sleeping", 32'(sleeping), 0);
      chk("R1 recovering", 32'(recovering), 0);
      chk("R1 rd_oe", 32'(rd_oe), 0);
      chk("R1 flags", 32'({wr_reject, busy_err}), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R9 normal writes then reads
      for (int i = 0; i < 8; i++) begin
         model[i] = DW'(8'h30 + i * 7);
         tick(2'b10, i, 32'(model[i]), 0);
      end
      for (int i = 0; i < 8; i++) tick(2'b01, i, 0, 1);
      tick(2'b11, 0, 0, 0);
      tick(2'b00, 0, 0, 0);

      // R2 entry timing
      sleep_pin = 1'b1;
      tick(2'b00, 0, 0, 0);
      chk("R2 sleeping after edge 1", 32'(sleeping), 0);
      tick(2'b00, 0, 0, 0);
      chk("R2 sleeping after edge 2", 32'(sleeping), 0);
      tick(2'b00, 0, 0, 0);
      chk("R2 sleeping after edge 3", 32'(sleeping), 0);
      tick(2'b00, 0, 0, 0);
      chk("R2 sleeping after edge 4", 32'(sleeping), 1);

      // R4 commands ignored while asleep
      tick(2'b01, 0, 0, 0);
      chk("R4 rd_oe asleep", 32'(rd_oe), 0);
      tick(2'b10, 0, 8'hEE, 0);
      tick(2'b10, 1, 8'hDD, 0);
      chk("R4 still sleeping", 32'(sleeping), 1);

      // R6 wake timing, R7 write rejection in the window
      sleep_pin = 1'b0;
      tick(2'b00, 0, 0, 0);
      tick(2'b00, 0, 0, 0);
      chk("R6 sleeping before window", 32'(sleeping), 1);
      chk("R6 recovering before window", 32'(recovering), 0);
      tick(2'b00, 0, 0, 0);
      chk("R6 sleeping at window open", 32'(sleeping), 0);
      chk("R6 recovering at window open", 32'(recovering), 1);
      tick(2'b01, 0, 0, 1);
      chk("R6 recovering second cycle", 32'(recovering), 1);
      tick(2'b10, 1, 8'h5A, 0);
      chk("R7 wr_reject pulse", 32'(wr_reject), 1);
      chk("R6 recovering closed", 32'(recovering), 0);
      tick(2'b00, 0, 0, 0);
      chk("R7 wr_reject single cycle", 32'(wr_reject), 0);

      // R5 contents kept, R4/R7 no stray writes
      for (int i = 0; i < 8; i++) tick(2'b01, i, 0, 1);
      tick(2'b00, 0, 0, 0);

      // R3 one-sample pulse aborts entry
      sleep_pin = 1'b1;
      tick(2'b00, 0, 0, 0);
      sleep_pin = 1'b0;
      for (int i = 0; i < 6; i++) begin
         tick(2'b00, 0, 0, 0);
         chk("R3 no sleep after short pulse", 32'({sleeping, recovering}), 0);
      end

      // R8 busy violation: reads kept on the bus through the entry
      sleep_pin = 1'b1;
      tick(2'b01, 2, 0, 1);
      chk("R8 no error before request", 32'(busy_err), 0);
      tick(2'b01, 3, 0, 1);
      tick(2'b01, 4, 0, 1);
      chk("R8 busy_err at request edge", 32'(busy_err), 1);
      tick(2'b01, 5, 0, 0);
      chk("R8 busy_err during entry", 32'(busy_err), 1);
      chk("R2 asleep after busy entry", 32'(sleeping), 1);
      tick(2'b00, 0, 0, 0);
      chk("R8 busy_err cleared", 32'(busy_err), 0);
      chk("R4 rd_oe low in sleep", 32'(rd_oe), 0);

      // wake and confirm normal writes resume
      sleep_pin = 1'b0;
      repeat (6) tick(2'b00, 0, 0, 0);
      chk("R6 back to awake", 32'({sleeping, recovering}), 0);
      model[6] = 8'hA6;
      tick(2'b10, 6, 8'hA6, 0);
      tick(2'b01, 6, 0, 1);
      tick(2'b01, 7, 0, 1);
      tick(2'b00, 0, 0, 0);
      tick(2'b00, 0, 0, 0);

      chk("R9 all reads returned", 32'(exp_q.size()), 0);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule